// File: doc/BRIEF.md
# Replacement-Link and Page-Status Lookup Table

This block keeps a RAM copy of two pieces of flash metadata that a block-mapped translation layer would otherwise read from the spare (out-of-band) area of each page. The first copy is a link table with one entry per virtual block. Each entry holds the physical block that receives rewrites for that virtual block, or says that no such block exists. The second copy is a written-page bitmap with one bit per page. A set bit means the page has been written at least once since its block was last reclaimed.

A request carries a sector number, laid out as {virtual block, page offset} with the virtual block in the upper bits. The block answers in the same cycle. It returns the replacement link of the sector's virtual block and the sector's written bit. From the written bit it also derives where a write must go and whether a read is illegal. The translator writes the link and bitmap updates in the same cycles that it writes the matching spare-area metadata. When a block is folded or erased, one update clears its link and loads a new bitmap row.

After reset the block is in a rebuild mode. In this mode a power-up scan of the flash streams link and page records into the block, one of each kind per cycle at most. A start pulse then switches the block to normal operation.

Top module: `repl_status_lut`

## Requirements
- R1: After reset every virtual block reports no replacement block (q_has_rep 0, q_rep_blk 0), every page reads as unwritten, and lut_ready is 0.
- R2: q_has_rep and q_rep_blk describe the virtual block in q_sector's upper VBLK_W bits in the same cycle as q_sector is applied. q_rep_blk is 0 whenever q_has_rep is 0.
- R3: q_route_rep is 1 (route the write to the replacement block) exactly when the queried page's written bit is 1. It is 0 (route to the primary block) when that bit is 0.
- R4: q_rd_illegal is 1 exactly when q_is_read is 1 and the queried page's written bit is 0.
- R5: A cycle with link_we 1 stores link_pblk as the replacement block of link_vblk, visible from the next cycle, in both modes.
- R6: In normal operation, a cycle with mark_we 1 sets the written bit of mark_sector from the next cycle. mark_val has no effect in this mode.
- R7: In normal operation, a cycle with fold_we 1 clears the replacement link of fold_vblk. It also loads that block's written bits from fold_keep, where bit i of fold_keep is page offset i. Other virtual blocks are left unchanged.
- R8: When a fold and a link update or mark update target the same virtual block in the same cycle, the fold result is what remains.
- R9: In rebuild mode, mark_we writes mark_val into the page's written bit, so a 0 clears it. fold_we has no effect in this mode.
- R10: A run_go pulse in rebuild mode raises lut_ready on the next cycle. lut_ready then stays 1 until reset, and further run_go pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_go | input | 1 | Leave rebuild mode |
| lut_ready | output | 1 | Normal operation enabled |
| q_sector | input | VBLK_W+PAGE_W | Queried sector {vblk, page} |
| q_is_read | input | 1 | Query is for a read |
| q_has_rep | output | 1 | Virtual block has a replacement block |
| q_rep_blk | output | PBLK_W | Replacement block number, 0 when none |
| q_written | output | 1 | Page written bit |
| q_route_rep | output | 1 | Write goes to replacement block |
| q_rd_illegal | output | 1 | Read of an unwritten page |
| link_we | input | 1 | Store a replacement link |
| link_vblk | input | VBLK_W | Virtual block of the link |
| link_pblk | input | PBLK_W | Physical replacement block |
| mark_we | input | 1 | Update a page written bit |
| mark_sector | input | VBLK_W+PAGE_W | Sector to update |
| mark_val | input | 1 | Bit value, used in rebuild mode only |
| fold_we | input | 1 | Fold or erase a virtual block |
| fold_vblk | input | VBLK_W | Virtual block being folded |
| fold_keep | input | 2**PAGE_W | Written bits after the fold |

## Verification
The combinational answers are tried in two ways. Read and write queries are applied to pages that are unwritten, written only during the scan, and written in normal operation; this separates the routing output from the illegal-read output. Scan records that clear a bit, and folds issued before the start pulse, show whether mark_val and fold_we are honoured or ignored according to the mode. A fold with a sparse keep mask next to an untouched neighbour block shows whether the fold reaches the right row. A single cycle in which link, mark and fold all hit one block pins down the update priority. Links on the highest virtual block and sector cover the address edges.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic {
    MODE_REBUILD = 1'b0,
    MODE_RUN     = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/lut_mode_ctrl.sv
module lut_mode_ctrl
  import lut_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_go,
  output logic ready
);
  lut_mode_e mode_q, mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = (mode_q == MODE_REBUILD) && run_go;
    mode_d  = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_REBUILD;
    else if (mode_en) mode_q <= mode_d;
  end

  assign ready = (mode_q == MODE_RUN);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/lut_rep_table.sv
module lut_rep_table #(
  parameter int VBLK_W = 3,
  parameter int PBLK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic [VBLK_W-1:0] link_vblk,
  input  logic [PBLK_W-1:0] link_pblk,
  input  logic              fold_en,
  input  logic [VBLK_W-1:0] fold_vblk,
  input  logic [VBLK_W-1:0] rd_vblk,
  output logic              rd_vld,
  output logic [PBLK_W-1:0] rd_pblk
);
  localparam int NV = 1 << VBLK_W;

  logic [NV-1:0]     vld_vec;
  logic [PBLK_W-1:0] pblk_arr [NV];

  for (genvar g = 0; g < NV; g++) begin : g_ent
    logic              hit_link, hit_fold, ent_en;
    logic              vld_q, vld_d;
    logic [PBLK_W-1:0] pblk_q, pblk_d;

    always_comb begin
      hit_link = link_en && (link_vblk == VBLK_W'(g));
      hit_fold = fold_en && (fold_vblk == VBLK_W'(g));
      ent_en   = hit_link || hit_fold;
      if (hit_fold) begin
        vld_d  = 1'b0;
        pblk_d = '0;
      end else begin
        vld_d  = 1'b1;
        pblk_d = link_pblk;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        pblk_q <= '0;
      end else if (ent_en) begin
        vld_q  <= vld_d;
        pblk_q <= pblk_d;
      end
    end

    assign vld_vec[g]  = vld_q;
    assign pblk_arr[g] = pblk_q;
  end

  assign rd_vld  = vld_vec[rd_vblk];
  assign rd_pblk = vld_vec[rd_vblk] ? pblk_arr[rd_vblk] : '0;

  // R7
  fold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> !vld_vec[$past(fold_vblk)]);

  // R5
  link_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !(fold_en && fold_vblk == link_vblk)) |=>
      (vld_vec[$past(link_vblk)] && pblk_arr[$past(link_vblk)] == $past(link_pblk)));
endmodule

// File: rtl/lut_page_bitmap.sv
module lut_page_bitmap #(
  parameter int VBLK_W = 3,
  parameter int PAGE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mark_en,
  input  logic [VBLK_W+PAGE_W-1:0] mark_sector,
  input  logic                     mark_val,
  input  logic                     fold_en,
  input  logic [VBLK_W-1:0]        fold_vblk,
  input  logic [(1<<PAGE_W)-1:0]   fold_keep,
  input  logic [VBLK_W+PAGE_W-1:0] rd_sector,
  output logic                     rd_bit
);
  localparam int NV = 1 << VBLK_W;
  localparam int NP = 1 << PAGE_W;

  logic [NV*NP-1:0] bm_flat;

  for (genvar g = 0; g < NV; g++) begin : g_row
    logic          hit_mark, hit_fold, row_en;
    logic [NP-1:0] row_q, row_d;

    always_comb begin
      hit_mark = mark_en && (mark_sector[VBLK_W+PAGE_W-1:PAGE_W] == VBLK_W'(g));
      hit_fold = fold_en && (fold_vblk == VBLK_W'(g));
      row_en   = hit_mark || hit_fold;
      row_d    = row_q;
      if (hit_fold) row_d = fold_keep;
      else          row_d[mark_sector[PAGE_W-1:0]] = mark_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q <= row_d;
    end

    assign bm_flat[g*NP +: NP] = row_q;
  end

  assign rd_bit = bm_flat[rd_sector];

  // R6
  mark_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && mark_val && !(fold_en && fold_vblk == mark_sector[VBLK_W+PAGE_W-1:PAGE_W]))
      |=> bm_flat[$past(mark_sector)]);

  // R7
  fold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> (bm_flat[$past(fold_vblk)*NP +: NP] == $past(fold_keep)));
endmodule

// File: rtl/repl_status_lut.sv
module repl_status_lut #(
  parameter int VBLK_W = 3,
  parameter int PAGE_W = 2,
  parameter int PBLK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_go,
  output logic                     lut_ready,
  input  logic [VBLK_W+PAGE_W-1:0] q_sector,
  input  logic                     q_is_read,
  output logic                     q_has_rep,
  output logic [PBLK_W-1:0]        q_rep_blk,
  output logic                     q_written,
  output logic                     q_route_rep,
  output logic                     q_rd_illegal,
  input  logic                     link_we,
  input  logic [VBLK_W-1:0]        link_vblk,
  input  logic [PBLK_W-1:0]        link_pblk,
  input  logic                     mark_we,
  input  logic [VBLK_W+PAGE_W-1:0] mark_sector,
  input  logic                     mark_val,
  input  logic                     fold_we,
  input  logic [VBLK_W-1:0]        fold_vblk,
  input  logic [(1<<PAGE_W)-1:0]   fold_keep
);
  localparam int SEC_W = VBLK_W + PAGE_W;

  logic ready;
  logic fold_en;
  logic mark_bit;
  logic wr_bit;

  lut_mode_ctrl u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .run_go(run_go),
    .ready (ready)
  );

  assign fold_en  = fold_we && ready;
  assign mark_bit = ready ? 1'b1 : mark_val;

  lut_rep_table #(.VBLK_W(VBLK_W), .PBLK_W(PBLK_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_en  (link_we),
    .link_vblk(link_vblk),
    .link_pblk(link_pblk),
    .fold_en  (fold_en),
    .fold_vblk(fold_vblk),
    .rd_vblk  (q_sector[SEC_W-1:PAGE_W]),
    .rd_vld   (q_has_rep),
    .rd_pblk  (q_rep_blk)
  );

  lut_page_bitmap #(.VBLK_W(VBLK_W), .PAGE_W(PAGE_W)) u_bm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_en    (mark_we),
    .mark_sector(mark_sector),
    .mark_val   (mark_bit),
    .fold_en    (fold_en),
    .fold_vblk  (fold_vblk),
    .fold_keep  (fold_keep),
    .rd_sector  (q_sector),
    .rd_bit     (wr_bit)
  );

  assign lut_ready    = ready;
  assign q_written    = wr_bit;
  assign q_route_rep  = wr_bit;
  assign q_rd_illegal = q_is_read && !wr_bit;

  // R9
  rebuild_fold_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !link_we && fold_we && q_has_rep && !run_go && $stable(q_sector))
      |=> q_has_rep);
endmodule

// File: tb/repl_status_lut_tb.sv
`timescale 1ns/1ps
module repl_status_lut_tb;
  localparam int VBLK_W = 3;
  localparam int PAGE_W = 2;
  localparam int PBLK_W = 4;
  localparam int NV = 1 << VBLK_W;
  localparam int NP = 1 << PAGE_W;

  logic clk, rst_n, run_go, lut_ready;
  logic [VBLK_W+PAGE_W-1:0] q_sector, mark_sector;
  logic q_is_read, q_has_rep, q_written, q_route_rep, q_rd_illegal;
  logic [PBLK_W-1:0] q_rep_blk, link_pblk;
  logic link_we, mark_we, mark_val, fold_we;
  logic [VBLK_W-1:0] link_vblk, fold_vblk;
  logic [NP-1:0] fold_keep;

  repl_status_lut #(.VBLK_W(VBLK_W), .PAGE_W(PAGE_W), .PBLK_W(PBLK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_go(run_go), .lut_ready(lut_ready),
    .q_sector(q_sector), .q_is_read(q_is_read), .q_has_rep(q_has_rep),
    .q_rep_blk(q_rep_blk), .q_written(q_written), .q_route_rep(q_route_rep),
    .q_rd_illegal(q_rd_illegal), .link_we(link_we), .link_vblk(link_vblk),
    .link_pblk(link_pblk), .mark_we(mark_we), .mark_sector(mark_sector),
    .mark_val(mark_val), .fold_we(fold_we), .fold_vblk(fold_vblk),
    .fold_keep(fold_keep)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [VBLK_W+PAGE_W-1:0] sec;
    logic has, wr, ill;
    logic [PBLK_W-1:0] blk;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  logic              m_has [NV];
  logic [PBLK_W-1:0] m_blk [NV];
  logic              m_bm  [NV*NP];
  logic              m_ready;

  always begin
    wait (exp_q.size() != 0);
    begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (q_has_rep !== e.has || q_rep_blk !== e.blk || q_written !== e.wr ||
          q_route_rep !== e.wr || q_rd_illegal !== e.ill) begin
        n_fail++;
        $display("FAIL %s sec=%0d act has=%0b blk=%0d wr=%0b route=%0b ill=%0b exp has=%0b blk=%0d wr=%0b route=%0b ill=%0b",
                 e.tag, e.sec, q_has_rep, q_rep_blk, q_written, q_route_rep, q_rd_illegal,
                 e.has, e.blk, e.wr, e.wr, e.ill);
      end
    end
  end

  task automatic query(input int sec, input bit rd, input string tag);
    exp_t e;
    int vb;
    @(negedge clk);
    q_sector  = (VBLK_W+PAGE_W)'(sec);
    q_is_read = rd;
    #1;
    vb = sec / NP;
    e.sec = q_sector;
    e.has = m_has[vb];
    e.blk = m_has[vb] ? m_blk[vb] : '0;
    e.wr  = m_bm[sec];
    e.ill = rd && !m_bm[sec];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic upd(input bit lw, input int lv, input int lp,
                     input bit mw, input int ms, input bit mv,
                     input bit fw, input int fv, input logic [NP-1:0] fk);
    @(negedge clk);
    link_we = lw; link_vblk = VBLK_W'(lv); link_pblk = PBLK_W'(lp);
    mark_we = mw; mark_sector = (VBLK_W+PAGE_W)'(ms); mark_val = mv;
    fold_we = fw; fold_vblk = VBLK_W'(fv); fold_keep = fk;
    @(posedge clk);
    #1;
    link_we = 1'b0; mark_we = 1'b0; fold_we = 1'b0;
    if (lw) begin m_has[lv] = 1'b1; m_blk[lv] = PBLK_W'(lp); end
    if (mw) m_bm[ms] = m_ready ? 1'b1 : mv;
    if (fw && m_ready) begin
      m_has[fv] = 1'b0;
      for (int i = 0; i < NP; i++) m_bm[fv*NP+i] = fk[i];
    end
  endtask

  task automatic go_pulse();
    @(negedge clk);
    run_go = 1'b1;
    @(posedge clk);
    #1;
    run_go = 1'b0;
    m_ready = 1'b1;
  endtask

  task automatic chk_ready(input bit exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (lut_ready !== exp) begin
      n_fail++;
      $display("FAIL %s lut_ready act=%0b exp=%0b", tag, lut_ready, exp);
    end
  endtask

  initial begin
    #(8*100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin m_has[i] = 1'b0; m_blk[i] = '0; end
    for (int i = 0; i < NV*NP; i++) m_bm[i] = 1'b0;
    m_ready = 1'b0;
    rst_n = 1'b0; run_go = 1'b0; q_sector = '0; q_is_read = 1'b0;
    link_we = 1'b0; link_vblk = '0; link_pblk = '0;
    mark_we = 1'b0; mark_sector = '0; mark_val = 1'b0;
    fold_we = 1'b0; fold_vblk = '0; fold_keep = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk_ready(1'b0, "R1 ready low after reset");
    query(0, 1'b1, "R1 R4 reset read sector 0");
    query(31, 1'b0, "R1 R2 reset write sector 31");
    query(9, 1'b1, "R1 reset read sector 9");

    // rebuild scan records
    upd(1, 2, 5, 0, 0, 0, 0, 0, '0);
    upd(0, 0, 0, 1, 9, 1'b1, 0, 0, '0);
    upd(0, 0, 0, 1, 11, 1'b1, 0, 0, '0);
    upd(0, 0, 0, 1, 11, 1'b0, 0, 0, '0);
    upd(0, 0, 0, 0, 0, 0, 1, 2, 4'b0000);
    query(9, 1'b1, "R9 R5 R2 scan link and mark kept, fold ignored");
    query(11, 1'b1, "R9 scan mark_val 0 clears");
    query(11, 1'b0, "R3 write to unwritten routes primary");
    chk_ready(1'b0, "R10 still rebuilding");

    go_pulse();
    chk_ready(1'b1, "R10 ready after run_go");

    // normal operation
    upd(0, 0, 0, 1, 3, 1'b0, 0, 0, '0);
    query(3, 1'b0, "R6 R3 mark sets despite mark_val 0");
    query(3, 1'b1, "R4 read of written page legal");
    query(2, 1'b0, "R3 neighbour page unwritten");
    upd(1, 0, 7, 0, 0, 0, 0, 0, '0);
    query(1, 1'b1, "R5 R2 link on vblk 0");

    upd(0, 0, 0, 0, 0, 0, 1, 2, 4'b0100);
    query(9, 1'b1, "R7 fold clears link and page 1");
    query(10, 1'b0, "R7 fold keeps page 2");
    query(8, 1'b1, "R7 fold page 0 cleared");
    query(3, 1'b0, "R7 other block untouched");
    query(0, 1'b1, "R7 other block link untouched");

    upd(1, 3, 9, 1, 13, 1'b1, 1, 3, 4'b0000);
    query(13, 1'b1, "R8 fold wins over link and mark");
    query(12, 1'b0, "R8 fold wins row");

    upd(1, 7, 15, 1, 31, 1'b1, 0, 0, '0);
    query(31, 1'b1, "R5 R6 top vblk and sector");
    query(28, 1'b1, "R4 top block unwritten page");

    go_pulse();
    chk_ready(1'b1, "R10 second run_go no effect");
    query(31, 1'b0, "R10 state kept after second run_go");

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule